// File: doc/BRIEF.md
# Weighted Two-Channel DMA Bus Arbiter

This block decides which of two DMA requesters, a transmit channel and a receive channel, owns a single shared data bus. A requester raises its request line. When the arbiter grants it, the requester keeps the bus for one transfer and ends that transfer with a one-cycle done pulse. The arbiter makes a new decision only at transfer boundaries: when the bus is idle, or in the cycle that the current owner reports done. A boundary decision shows as the new grant on the next clock edge, so back-to-back transfers need no idle cycle between them.

A mode input selects the policy. The first policy is ratio-weighted round-robin: under contention, receive takes a programmable run of consecutive grants, and then transmit takes one. The second policy is strict receive-first priority. Each channel has an enable input that masks its request. A bus error response during a granted transfer is treated as fatal. All grants stop, and a sticky status output records the fatal condition and which channel held the bus. Only the asynchronous reset clears this state.

Top module: `dma_bus_arb`

## Requirements
- R1: After reset, both grants are low, `fatal_o` is 0 and `fatal_chan_o` is 0.
- R2: When only one enabled channel is requesting at a decision point, that channel is granted on the next clock edge, in either mode.
- R3: With `fixed_prio_i`=1 and both enabled channels requesting at a decision point, the receive channel is granted.
- R4: With `fixed_prio_i`=0 and both enabled channels requesting continuously, and with `ratio_i`=k, the grants repeat the pattern of k+1 receive grants followed by one transmit grant. The pattern starts with receive after an idle bus.
- R5: At most one grant is high. A grant is held until the granted channel pulses its own done input. A done pulse from the other channel has no effect. The decision made in the done cycle appears on the next edge.
- R6: A request from a channel whose enable input is 0 is ignored. No grant goes to that channel.
- R7: The receive-run count restarts at zero at every decision where the two channels are not both requesting. After such a decision, a full run of k+1 receive grants is again given before transmit.
- R8: A change of `fixed_prio_i` or `ratio_i` does not disturb a grant in progress. The change applies from the next decision.
- R9: `bus_err_i` high while a grant is active drops both grants on the next edge and sets `fatal_o`=1. In the same edge, `fatal_chan_o` is set to 0 if transmit held the bus and to 1 if receive held it. `bus_err_i` while no grant is active is ignored.
- R10: While `fatal_o` is 1, no grant is issued whatever the requests or done inputs do, and `fatal_o` and `fatal_chan_o` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fixed_prio_i | input | 1 | 1: receive-first priority, 0: weighted round-robin |
| ratio_i | input | 2 | Receive run length minus one under round-robin |
| tx_en_i | input | 1 | Transmit channel enable |
| rx_en_i | input | 1 | Receive channel enable |
| tx_req_i | input | 1 | Transmit bus request |
| rx_req_i | input | 1 | Receive bus request |
| tx_done_i | input | 1 | Transmit transfer complete pulse |
| rx_done_i | input | 1 | Receive transfer complete pulse |
| bus_err_i | input | 1 | Bus error response for the current transfer |
| tx_gnt_o | output | 1 | Transmit owns the bus |
| rx_gnt_o | output | 1 | Receive owns the bus |
| fatal_o | output | 1 | Sticky fatal bus error flag |
| fatal_chan_o | output | 1 | Channel granted at the fatal error (0 transmit, 1 receive) |

## Verification
A corrupted receive-run count does not show at the ports until contention occurs. It then shows within one ratio period, at most five grants, as a transmit grant in the wrong slot or as a missing one. A grant register that drops early or changes owner shows within one cycle as a grant that changes before its done pulse. A fatal flag that is lost or not set shows in the cycle after the error, as a grant that is still present or that returns. The stale-credit sequence and the mid-transfer mode switch are needed because the count and the mode affect only later decisions.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {CH_TX = 1'b0, CH_RX = 1'b1} chan_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter int CNT_W   = RATIO_W + 1
) (
  input  logic               fixed_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [CNT_W-1:0]   run_i,
  input  logic               tx_vld_i,
  input  logic               rx_vld_i,
  output logic               win_vld_o,
  output chan_e              win_o
);
  logic both;
  assign both      = tx_vld_i && rx_vld_i;
  assign win_vld_o = tx_vld_i || rx_vld_i;

  always_comb begin
    if (!both)        win_o = rx_vld_i ? CH_RX : CH_TX;
    else if (fixed_i) win_o = CH_RX;
    // receive keeps the bus while its run is shorter than ratio+1
    else if (run_i <= CNT_W'(ratio_i)) win_o = CH_RX;
    else              win_o = CH_TX;
  end
endmodule

// File: rtl/arb_ratio_cnt.sv
module arb_ratio_cnt
  import arb_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter int CNT_W   = RATIO_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             decide_i,
  input  logic             both_i,
  input  logic             fixed_i,
  input  chan_e            win_i,
  output logic [CNT_W-1:0] run_o
);
  localparam logic [CNT_W-1:0] RunMax = CNT_W'(1 << RATIO_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_o <= '0;
    else if (decide_i) begin
      if (!both_i || fixed_i)           run_o <= '0;
      else if (win_i == CH_RX)          run_o <= run_o + 1'b1;
      else                              run_o <= '0;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o <= RunMax); // R4
  AST_RUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !both_i) |=> (run_o == '0)); // R7
endmodule

// File: rtl/arb_fatal.sv
module arb_fatal
  import arb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  err_i,
  input  chan_e chan_i,
  output logic  fatal_o,
  output logic  chan_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fatal_o <= 1'b0;
      chan_o  <= 1'b0;
    end else if (err_i && !fatal_o) begin
      fatal_o <= 1'b1;
      chan_o  <= (chan_i == CH_RX);
    end
  end

  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> (fatal_o && $stable(chan_o))); // R10
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import arb_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fixed_prio_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               tx_en_i,
  input  logic               rx_en_i,
  input  logic               tx_req_i,
  input  logic               rx_req_i,
  input  logic               tx_done_i,
  input  logic               rx_done_i,
  input  logic               bus_err_i,
  output logic               tx_gnt_o,
  output logic               rx_gnt_o,
  output logic               fatal_o,
  output logic               fatal_chan_o
);
  localparam int CNT_W = RATIO_W + 1;

  logic             busy_q;
  chan_e            chan_q;
  logic             tx_vld, rx_vld, both;
  logic             cur_done, err_hit, decide;
  logic             win_vld;
  chan_e            win;
  logic [CNT_W-1:0] run;

  assign tx_vld   = tx_req_i && tx_en_i;
  assign rx_vld   = rx_req_i && rx_en_i;
  assign both     = tx_vld && rx_vld;
  assign cur_done = (chan_q == CH_RX) ? rx_done_i : tx_done_i;
  assign err_hit  = busy_q && bus_err_i;
  assign decide   = !fatal_o && !err_hit && (!busy_q || cur_done);

  arb_pick #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_pick (
    .fixed_i   (fixed_prio_i),
    .ratio_i   (ratio_i),
    .run_i     (run),
    .tx_vld_i  (tx_vld),
    .rx_vld_i  (rx_vld),
    .win_vld_o (win_vld),
    .win_o     (win)
  );

  arb_ratio_cnt #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .decide_i (decide),
    .both_i   (both),
    .fixed_i  (fixed_prio_i),
    .win_i    (win),
    .run_o    (run)
  );

  arb_fatal u_fatal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (err_hit),
    .chan_i  (chan_q),
    .fatal_o (fatal_o),
    .chan_o  (fatal_chan_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      chan_q <= CH_TX;
    end else if (err_hit) begin
      busy_q <= 1'b0;
    end else if (decide) begin
      busy_q <= win_vld;
      if (win_vld) chan_q <= win;
    end
  end

  assign tx_gnt_o = busy_q && (chan_q == CH_TX);
  assign rx_gnt_o = busy_q && (chan_q == CH_RX);

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_gnt_o, rx_gnt_o})); // R5
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_gnt_o && !tx_done_i && !bus_err_i) || (rx_gnt_o && !rx_done_i && !bus_err_i))
    |=> ($stable(tx_gnt_o) && $stable(rx_gnt_o))); // R5
  AST_FIXED_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && fixed_prio_i && tx_vld && rx_vld) |=> rx_gnt_o); // R3
  AST_LONE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && tx_vld && !rx_vld) |=> tx_gnt_o); // R2
  AST_EN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_gnt_o) |-> $past(tx_en_i)); // R6
  AST_ERR_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_gnt_o || rx_gnt_o) && bus_err_i) |=> (fatal_o && !tx_gnt_o && !rx_gnt_o)); // R9
  AST_NO_GNT_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> (!tx_gnt_o && !rx_gnt_o)); // R10
endmodule

// File: tb/dma_bus_arb_tb.sv
`timescale 1ns/1ps
module dma_bus_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fixed_prio, tx_en, rx_en, tx_req, rx_req, tx_done, rx_done, bus_err;
  logic [1:0] ratio;
  logic       tx_gnt, rx_gnt, fatal, fatal_chan;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  dma_bus_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fixed_prio_i(fixed_prio), .ratio_i(ratio),
    .tx_en_i(tx_en), .rx_en_i(rx_en), .tx_req_i(tx_req), .rx_req_i(rx_req),
    .tx_done_i(tx_done), .rx_done_i(rx_done), .bus_err_i(bus_err),
    .tx_gnt_o(tx_gnt), .rx_gnt_o(rx_gnt), .fatal_o(fatal), .fatal_chan_o(fatal_chan)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 none, 1 tx, 2 rx, 3 both
  function automatic int gstate();
    return {30'd0, rx_gnt, tx_gnt};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; fixed_prio = 1'b0; ratio = 2'd0; tx_en = 1'b1; rx_en = 1'b1;
    tx_req = 1'b0; rx_req = 1'b0; tx_done = 1'b0; rx_done = 1'b0; bus_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // wait at negedge for a grant; returns gstate or 0 on timeout
  task automatic wait_gnt(output int g);
    g = 0;
    for (int i = 0; i < 20; i++) begin
      if (tx_gnt || rx_gnt) begin g = gstate(); break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_done();
    if (tx_gnt) tx_done = 1'b1;
    if (rx_gnt) rx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; rx_done = 1'b0;
  endtask

  task automatic drain();
    tx_req = 1'b0; rx_req = 1'b0;
    if (tx_gnt || rx_gnt) pulse_done();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 grants", gstate(), 0);
    check("R1 fatal", fatal, 0);
    check("R1 fatal_chan", fatal_chan, 0);
  endtask

  task automatic t_single();
    do_reset();
    tx_req = 1'b1;
    @(negedge clk);
    check("R2 lone tx rr", gstate(), 1);
    pulse_done();
    check("R2 lone tx again", gstate(), 1);
    drain();
    fixed_prio = 1'b1; rx_req = 1'b1;
    @(negedge clk);
    check("R2 lone rx fixed", gstate(), 2);
    drain();
  endtask

  task automatic t_ratio(input int k);
    int g;
    do_reset();
    ratio = 2'(k);
    tx_req = 1'b1; rx_req = 1'b1;
    for (int i = 0; i < 2 * (k + 2); i++) begin
      wait_gnt(g);
      check($sformatf("R4 ratio %0d slot %0d", k, i), g, ((i % (k + 2)) < (k + 1)) ? 2 : 1);
      pulse_done();
    end
    drain();
  endtask

  task automatic t_fixed();
    int g;
    do_reset();
    fixed_prio = 1'b1;
    tx_req = 1'b1; rx_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_gnt(g);
      check($sformatf("R3 fixed slot %0d", i), g, 2);
      pulse_done();
    end
    drain();
  endtask

  task automatic t_hold();
    do_reset();
    fixed_prio = 1'b1; tx_req = 1'b1;
    @(negedge clk);
    check("R5 tx granted", gstate(), 1);
    rx_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 held vs rx", gstate(), 1);
    rx_done = 1'b1;
    @(negedge clk);
    rx_done = 1'b0;
    check("R5 foreign done ignored", gstate(), 1);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    check("R5 back-to-back rx", gstate(), 2);
    drain();
  endtask

  task automatic t_enable();
    do_reset();
    tx_en = 1'b0; tx_req = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 disabled tx ignored", gstate(), 0);
    tx_en = 1'b1;
    @(negedge clk);
    check("R6 enabled tx granted", gstate(), 1);
    drain();
  endtask

  task automatic t_stale();
    int g;
    do_reset();
    ratio = 2'd1;
    tx_req = 1'b1; rx_req = 1'b1;
    wait_gnt(g);
    check("R7 first rx", g, 2);
    tx_req = 1'b0;
    pulse_done();
    check("R7 lone rx", gstate(), 2);
    tx_req = 1'b1;
    pulse_done();
    check("R7 fresh run 1", gstate(), 2);
    pulse_done();
    check("R7 fresh run 2", gstate(), 2);
    pulse_done();
    check("R7 tx after run", gstate(), 1);
    drain();
  endtask

  task automatic t_mode();
    int g;
    do_reset();
    ratio = 2'd0;
    tx_req = 1'b1; rx_req = 1'b1;
    wait_gnt(g);
    check("R8 rr first rx", g, 2);
    fixed_prio = 1'b1; ratio = 2'd3;
    repeat (2) @(negedge clk);
    check("R8 grant undisturbed", gstate(), 2);
    pulse_done();
    check("R8 fixed applies", gstate(), 2);
    drain();
  endtask

  task automatic t_fatal();
    do_reset();
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    check("R9 idle error ignored", fatal, 0);
    tx_req = 1'b1;
    @(negedge clk);
    check("R9 tx granted", gstate(), 1);
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    check("R9 grants dropped", gstate(), 0);
    check("R9 fatal set", fatal, 1);
    check("R9 chan tx", fatal_chan, 0);
    rx_req = 1'b1;
    tx_done = 1'b1; rx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; rx_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 no grant", gstate(), 0);
    check("R10 fatal held", fatal, 1);
    check("R10 chan held", fatal_chan, 0);
    do_reset();
    check("R1 fatal cleared", fatal, 0);
    rx_req = 1'b1;
    @(negedge clk);
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    check("R9 chan rx", fatal_chan, 1);
    check("R9 fatal rx", fatal, 1);
  endtask

  initial begin
    t_reset();
    t_single();
    for (int k = 0; k < 4; k++) t_ratio(k);
    t_fixed();
    t_hold();
    t_enable();
    t_stale();
    t_mode();
    t_fatal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule